// File: doc/BRIEF.md
# Programmable Event Crossbar

This block steers event lines from a wide input bus onto a set of output lines. Each output picks exactly one input through its own 32-bit control word, and a separate gate bit in that word lets software keep the output quiet while the select is being set up. The control words sit behind a plain register strobe interface, next to a read-only identification word at word zero.

The routed value is captured in a flip-flop in the functional clock domain. Every output therefore lags its selected input by exactly one clock. The same datapath carries level-type events, where the output tracks the input level, and single-cycle pulse events, where each input pulse produces one output pulse. The input count, the output count and the event kind are parameters. The default build has 56 inputs and 48 outputs.

Top module: `event_router`

## Requirements
- R1: Reading byte offset 0x00 returns 0x66947900. Writes to that offset change nothing that can be read back.
- R2: The control word for output y sits at byte offset 4 + 4·y. Bits 6:0 hold the input select and bit 16 holds the output gate. Both fields read back as written.
- R3: Bits 31:17 and 15:7 of a control word always read as zero, even after a write of all ones.
- R4: While reset is high, and after it is released, every select and gate is zero, every output is low and the read data bus is zero.
- R5: While an output's gate bit is 0, that output stays low whatever its inputs do.
- R6: When an output is gated on and its select is below the input count, the output at clock edge k+1 equals the selected input sampled at edge k. A held level is therefore followed with a one-cycle delay.
- R7: A select value at or above the input count (for example 56 or 100 in the default build) keeps the output low.
- R8: Byte offsets past the last control word ignore writes and read as zero.
- R9: A control write at edge k changes routing from edge k+1 onward. An event sampled at edge k still uses the old route, and each output follows exactly one route in any cycle.
- R10: Read data appears on the clock after the read strobe. When no read was issued, the read bus is zero.
- R11: A one-cycle input pulse on a routed input produces exactly one one-cycle output pulse. When no input is active, no output pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional and register clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the clock after bus_rd |
| ev_in | input | N_IN | Event inputs |
| ev_out | output | N_OUT | Routed, gated, registered event outputs |

## Verification
A corrupted select or gate register does not show on its own output until the first event arrives on the affected input. It then appears as a missing or spurious bit on ev_out one clock after that input moves. Readback of the same control word exposes the stored fields on the clock after the read strobe, so the bench compares every output bit and every read word against a register model on every clock. The bench also drives dense random input traffic, so a wrong route shows within a few cycles.

// File: rtl/evr_pkg.sv
package evr_pkg;
  localparam int          SEL_W   = 7;
  localparam int          EN_BIT  = 16;
  localparam logic [31:0] ID_WORD = 32'h6694_7900;
  localparam logic [31:0] CTL_MASK = (32'd1 << EN_BIT) | ((32'd1 << SEL_W) - 32'd1);
endpackage

// File: rtl/evr_regs.sv
module evr_regs
  import evr_pkg::*;
#(
  parameter int N_OUT  = 48,
  parameter int ADDR_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        wr_en,
  input  logic                        rd_en,
  input  logic [ADDR_W-1:0]           addr,
  input  logic [31:0]                 wdata,
  output logic [31:0]                 rdata,
  output logic [N_OUT-1:0][SEL_W-1:0] sel_q,
  output logic [N_OUT-1:0]            en_q
);
  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [31:0]      rd_word;
  logic             unused_bits;

  assign idx         = addr[ADDR_W-1:2];
  assign unused_bits = ^{wdata[31:EN_BIT+1], wdata[EN_BIT-1:SEL_W], addr[1:0]};

  // control storage: word index o+1 belongs to output o
  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      en_q  <= '0;
    end else if (wr_en) begin
      for (int o = 0; o < N_OUT; o++) begin
        if (idx == IDX_W'(o + 1)) begin
          sel_q[o] <= wdata[SEL_W-1:0];
          en_q[o]  <= wdata[EN_BIT];
        end
      end
    end
  end

  // readback mux, reserved bits left at zero
  always_comb begin
    rd_word = '0;
    if (idx == '0) rd_word = ID_WORD;
    for (int o = 0; o < N_OUT; o++) begin
      if (idx == IDX_W'(o + 1)) begin
        rd_word[SEL_W-1:0] = sel_q[o];
        rd_word[EN_BIT]    = en_q[o];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata <= '0;
    else if (rd_en) rdata <= rd_word;
    else            rdata <= '0;
  end

  a_r1_id_read: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && rd_en && idx == '0) |-> rdata == ID_WORD);

  a_r3_rsvd_zero: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && rd_en && idx != '0) |-> (rdata & ~CTL_MASK) == '0);

  a_r10_idle_bus: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !rd_en) |-> rdata == '0);
endmodule

// File: rtl/evr_route.sv
module evr_route
  import evr_pkg::*;
#(
  parameter int N_IN     = 56,
  parameter int N_OUT    = 48,
  parameter bit EV_PULSE = 1'b0
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [N_IN-1:0]             ev_in,
  input  logic [N_OUT-1:0][SEL_W-1:0] sel,
  input  logic [N_OUT-1:0]            en,
  output logic [N_OUT-1:0]            ev_out
);
  localparam int SPAN = 1 << SEL_W;

  // zero-padded input bus: out-of-range selects land on constant zero
  logic [SPAN-1:0]  ev_pad;
  logic [N_OUT-1:0] hit;

  always_comb begin
    ev_pad = '0;
    ev_pad[N_IN-1:0] = ev_in;
  end

  genvar o;
  generate
    for (o = 0; o < N_OUT; o++) begin : g_out
      assign hit[o] = en[o] & ev_pad[sel[o]];

      a_r5_gate_off: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && !en[o]) |-> !ev_out[o]);

      a_r7_sel_range: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && sel[o] >= SEL_W'(N_IN)) |-> !ev_out[o]);

      a_r6_one_cycle: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && en[o] && sel[o] < SEL_W'(N_IN)) |-> ev_out[o] == $past(ev_pad[sel[o]]));
    end

    if (EV_PULSE) begin : g_pulse
      a_r11_no_orphan: assert property (@(posedge clk) disable iff (rst)
        $past(!rst && ev_in == '0) |-> ev_out == '0);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) ev_out <= '0;
    else     ev_out <= hit;
  end

  a_r4_reset_quiet: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> ev_out == '0);
endmodule

// File: rtl/event_router.sv
module event_router
  import evr_pkg::*;
#(
  parameter int N_IN     = 56,
  parameter int N_OUT    = 48,
  parameter bit EV_PULSE = 1'b0,
  parameter int ADDR_W   = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic [N_IN-1:0]   ev_in,
  output logic [N_OUT-1:0]  ev_out
);
  logic [N_OUT-1:0][SEL_W-1:0] sel_q;
  logic [N_OUT-1:0]            en_q;

  evr_regs #(.N_OUT(N_OUT), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd),
    .addr(bus_addr), .wdata(bus_wdata), .rdata(bus_rdata),
    .sel_q(sel_q), .en_q(en_q)
  );

  evr_route #(.N_IN(N_IN), .N_OUT(N_OUT), .EV_PULSE(EV_PULSE)) u_route (
    .clk(clk), .rst(rst), .ev_in(ev_in), .sel(sel_q), .en(en_q), .ev_out(ev_out)
  );
endmodule

// File: tb/event_router_test.sv
`timescale 1ns/1ps
module event_router_test;
  localparam int N_IN  = 56;
  localparam int N_OUT = 48;
  localparam logic [31:0] ID = 32'h6694_7900;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              wr = 1'b0;
  logic              rd = 1'b0;
  logic [7:0]        addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       rdata;
  logic [N_IN-1:0]   ev_in = '0;
  logic [N_OUT-1:0]  ev_out;

  int  checks = 0;
  int  errors = 0;
  bit  sb_on = 1'b0;
  bit  done = 1'b0;

  logic [6:0]       m_sel [N_OUT];
  logic             m_en  [N_OUT];
  logic [N_OUT-1:0] exp_out;
  logic [31:0]      exp_rd;

  always #5 clk = ~clk;

  event_router uut (
    .clk(clk), .rst(rst), .bus_wr(wr), .bus_rd(rd), .bus_addr(addr),
    .bus_wdata(wdata), .bus_rdata(rdata), .ev_in(ev_in), .ev_out(ev_out)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] model_word(int idx);
    if (idx == 0) return ID;
    if (idx >= 1 && idx <= N_OUT)
      return {15'd0, m_en[idx-1], 9'd0, m_sel[idx-1]};
    return 32'd0;
  endfunction

  function automatic logic route_bit(int o, logic [N_IN-1:0] v);
    if (!m_en[o]) return 1'b0;
    if (int'(m_sel[o]) >= N_IN) return 1'b0;
    return v[m_sel[o]];
  endfunction

  // register model, advanced on the same edges as the design
  always @(posedge clk) begin
    if (rst) begin
      for (int o = 0; o < N_OUT; o++) begin
        m_sel[o] <= '0;
        m_en[o]  <= 1'b0;
      end
      exp_out <= '0;
      exp_rd  <= '0;
    end else begin
      for (int o = 0; o < N_OUT; o++) exp_out[o] <= route_bit(o, ev_in);
      exp_rd <= rd ? model_word(int'(addr[7:2])) : 32'd0;
      if (wr && addr[7:2] >= 1 && int'(addr[7:2]) <= N_OUT) begin
        m_sel[addr[7:2]-1] <= wdata[6:0];
        m_en[addr[7:2]-1]  <= wdata[16];
      end
    end
  end

  // scoreboard between edges
  always @(negedge clk) begin
    if (sb_on) begin
      chk("R6 ev_out vs model", 64'(ev_out), 64'(exp_out));
      chk("R10 rdata vs model", 64'(rdata), 64'(exp_rd));
    end
  end

  task automatic wr_reg(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic rd_reg(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    d = rdata;
  endtask

  function automatic logic [7:0] ctl(int y);
    return 8'(4 + 4 * y);
  endfunction

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    logic [31:0] seed_val;
    seed_val = $urandom(32'd4242);

    // R4: reset state
    repeat (3) @(negedge clk);
    chk("R4 ev_out in reset", 64'(ev_out), 64'd0);
    chk("R4 rdata in reset", 64'(rdata), 64'd0);
    rst = 1'b0;
    sb_on = 1'b1;
    rd_reg(ctl(0), d);          chk("R4 ctl0 after reset", 64'(d), 64'd0);
    rd_reg(ctl(N_OUT - 1), d);  chk("R4 last ctl after reset", 64'(d), 64'd0);
    ev_in = '1;
    @(negedge clk); @(negedge clk);
    chk("R4 outputs gated after reset", 64'(ev_out), 64'd0);
    ev_in = '0;

    // R1: identification word
    rd_reg(8'h00, d);           chk("R1 id read", 64'(d), 64'(ID));
    wr_reg(8'h00, 32'h0);
    rd_reg(8'h00, d);           chk("R1 id after write", 64'(d), 64'(ID));

    // R3 / R2: field layout and reserved bits
    wr_reg(ctl(5), 32'hFFFF_FFFF);
    rd_reg(ctl(5), d);          chk("R3 reserved bits read zero", 64'(d), 64'h0001_007F);
    wr_reg(ctl(5), 32'h0001_0023);
    rd_reg(ctl(5), d);          chk("R2 readback", 64'(d), 64'h0001_0023);

    // R8: beyond the last control word
    wr_reg(ctl(N_OUT), 32'hFFFF_FFFF);
    wr_reg(8'hFC, 32'hFFFF_FFFF);
    rd_reg(ctl(N_OUT), d);      chk("R8 read beyond end", 64'(d), 64'd0);
    rd_reg(8'hFC, d);           chk("R8 read top offset", 64'(d), 64'd0);
    rd_reg(ctl(N_OUT - 1), d);  chk("R8 last ctl untouched", 64'(d), 64'd0);

    // R5: gate off
    wr_reg(ctl(3), 32'h0000_000A);
    ev_in = '1;
    @(negedge clk); @(negedge clk);
    chk("R5 gated output low", 64'(ev_out[3]), 64'd0);
    ev_in = '0;

    // R7: out-of-range selects, boundary 55/56
    wr_reg(ctl(4), 32'h0001_0064);
    wr_reg(ctl(6), 32'h0001_0038);
    wr_reg(ctl(8), 32'h0001_0037);
    ev_in = '1;
    @(negedge clk); @(negedge clk);
    chk("R7 select 100 low", 64'(ev_out[4]), 64'd0);
    chk("R7 select 56 low", 64'(ev_out[6]), 64'd0);
    chk("R7 select 55 routes", 64'(ev_out[8]), 64'd1);
    ev_in = '0;
    @(negedge clk);

    // R6: level follows with one-cycle delay
    wr_reg(ctl(7), 32'h0001_000C);
    ev_in = N_IN'(1) << 12;
    chk("R6 not before edge", 64'(ev_out[7]), 64'd0);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk("R6 level held", 64'(ev_out[7]), 64'd1);
    end
    ev_in = '0;
    @(negedge clk);
    chk("R6 level released", 64'(ev_out[7]), 64'd0);

    // R11: single pulse gives single pulse
    ev_in = N_IN'(1) << 12;
    @(negedge clk);
    ev_in = '0;
    chk("R11 pulse out", 64'(ev_out[7]), 64'd1);
    @(negedge clk);
    chk("R11 pulse ends", 64'(ev_out[7]), 64'd0);

    // R9: changeover from input 20 to input 21 on output 9
    wr_reg(ctl(9), 32'h0001_0014);
    @(negedge clk);
    wr = 1'b1; addr = ctl(9); wdata = 32'h0001_0015;
    ev_in = N_IN'(1) << 21;
    @(negedge clk);
    wr = 1'b0;
    chk("R9 new route not early", 64'(ev_out[9]), 64'd0);
    ev_in = N_IN'(1) << 20;
    @(negedge clk);
    chk("R9 old route gone", 64'(ev_out[9]), 64'd0);
    ev_in = N_IN'(1) << 21;
    @(negedge clk);
    chk("R9 new route live", 64'(ev_out[9]), 64'd1);
    wr = 1'b1; addr = ctl(9); wdata = 32'h0001_0014;
    ev_in = N_IN'(1) << 20;
    @(negedge clk);
    wr = 1'b0;
    ev_in = '0;
    chk("R9 old route in write cycle", 64'(ev_out[9]), 64'd0);
    @(negedge clk);

    // random traffic checked by the scoreboard
    for (int n = 0; n < 4000; n++) begin
      @(negedge clk);
      wr    = ($urandom % 4) == 0;
      rd    = ($urandom % 3) == 0;
      addr  = {6'($urandom % 52), 2'b00};
      wdata = $urandom;
      if ($urandom % 2 == 0) wdata[6:0] = 7'($urandom % N_IN);
      ev_in = N_IN'({$urandom, $urandom} & {$urandom, $urandom});
    end
    @(negedge clk);
    wr = 1'b0; rd = 1'b0; ev_in = '0;
    repeat (3) @(negedge clk);
    finish_run();
  end
endmodule